// File: doc/BRIEF.md
# Video Event Interrupt Controller

This block gathers seven interrupt events from a video display and capture controller and merges them into one interrupt line. The events are the leading and trailing edges of the display vertical sync, the leading and trailing edges of the capture vertical sync, single-cycle pulses that flag a change in horizontal or vertical input frequency, and the expiry of a 16-bit periodic count-down timer. All inputs are assumed to be synchronous to `clk` and active high.

Software reaches the block through a byte-wide synchronous register bus. One index holds the per-source enable mask, which can be read and written. A second index returns the latched event status when read, and clears the status bits whose write-data bits are 1 when written. Status bits latch whether or not their source is enabled. The enables only gate which latched bits drive the interrupt line.

Two small state machines sit under the register bank. Each vertical sync has an edge tracker with states `SYNC_LOW` and `SYNC_HIGH`. The transition `SYNC_LOW`→`SYNC_HIGH` emits a leading-edge event, and `SYNC_HIGH`→`SYNC_LOW` emits a trailing-edge event. The timer has states `TMR_IDLE` and `TMR_COUNT`. A load of a nonzero value takes it `TMR_IDLE`→`TMR_COUNT`, or keeps it in `TMR_COUNT`. A load of zero takes it `TMR_COUNT`→`TMR_IDLE`. In `TMR_COUNT` it stays put on the expiry step, where it reloads the last loaded value and fires its event.

Top module: `vid_evt_irq`

## Requirements
- R1: After reset the enable register, the status register and `irq` are all 0.
- R2: Index 0xB4 is the enable register. A write stores the data and a read returns it, except bit 0, which always reads 0.
- R3: On the cycle after `disp_vsync` rises, status bit 6 is set. On the cycle after it falls, status bit 5 is set.
- R4: On the cycle after `cap_vsync` rises, status bit 4 is set. On the cycle after it falls, status bit 3 is set.
- R5: A one-cycle pulse on `hfreq_chg` sets status bit 7, and one on `vfreq_chg` sets status bit 2, from the next cycle on.
- R6: After `tmr_load` with a nonzero value N, status bit 1 is set by the N-th clock edge on which `tmr_tick` is high. The count then reloads N and fires again every N ticks. Cycles with `tmr_tick` low do not advance the count.
- R7: Loading the timer with 0 stops it, and no timer event follows however many ticks arrive.
- R8: Status bits latch their events regardless of the enables. `irq` is 1 exactly when some status bit and its enable bit are both 1.
- R9: Reading index 0xB5 returns the status. Writing 0xB5 clears each status bit whose data bit is 1 and leaves the bits written 0 unchanged. Status bit 0 always reads 0.
- R10: When an event and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R11: A write to any other index changes neither register, and a read of any other index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register index |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| disp_vsync | input | 1 | Display vertical sync, active high |
| cap_vsync | input | 1 | Capture vertical sync, active high |
| hfreq_chg | input | 1 | Horizontal frequency change pulse |
| vfreq_chg | input | 1 | Vertical frequency change pulse |
| tmr_tick | input | 1 | Timer decrement enable |
| tmr_load | input | 1 | Timer load strobe |
| tmr_value | input | 16 | Timer reload value |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is an event landing on exactly the edge where software writes a 1 to clear the same bit. From the ports that needs a bus write and a source pulse aligned to the same clock. The stimulus asserts `hfreq_chg` in the very cycle that carries the clear write to 0xB5, then reads the status back. A second hard case is telling a timer that counts correctly apart from one that is off by one tick. The bench stops the ticks one short of expiry, confirms that the status is still clear while the count is held, and then supplies the final tick.

// File: rtl/vid_evt_irq_pkg.sv
package vid_evt_irq_pkg;

    localparam int REG_W = 8;

    // status / enable bit positions (software decodes these)
    localparam int BIT_HFREQ     = 7;
    localparam int BIT_DISP_LEAD = 6;
    localparam int BIT_DISP_TRL  = 5;
    localparam int BIT_CAP_LEAD  = 4;
    localparam int BIT_CAP_TRL   = 3;
    localparam int BIT_VFREQ     = 2;
    localparam int BIT_TIMER     = 1;

    localparam logic [REG_W-1:0] LIVE_MASK = 8'hFE;

    localparam int NUM_SYNC = 2;
    localparam int SYNC_DISP = 0;
    localparam int SYNC_CAP  = 1;

    typedef enum logic {
        SYNC_LOW  = 1'b0,
        SYNC_HIGH = 1'b1
    } sync_state_t;

    typedef enum logic {
        TMR_IDLE  = 1'b0,
        TMR_COUNT = 1'b1
    } tmr_state_t;

endpackage

// File: rtl/vid_sync_edge.sv
module vid_sync_edge
    import vid_evt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic lead_evt,
    output logic trail_evt
);

    sync_state_t state_q;
    sync_state_t state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYNC_LOW:  if (sync_in)  state_d = SYNC_HIGH;
            SYNC_HIGH: if (!sync_in) state_d = SYNC_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SYNC_LOW;
        else        state_q <= state_d;
    end

    // outputs: one pulse per transition
    always_comb begin
        lead_evt  = 1'b0;
        trail_evt = 1'b0;
        unique case (state_q)
            SYNC_LOW:  lead_evt  = sync_in;
            SYNC_HIGH: trail_evt = !sync_in;
        endcase
    end

endmodule

// File: rtl/vid_cdown_timer.sv
module vid_cdown_timer
    import vid_evt_irq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    input  logic             tick,
    output logic             zero_evt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_t       state_q;
    tmr_state_t       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;
    logic             last_step;

    assign last_step = tick && !load && (cnt_q == ONE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE:  if (load && (value != '0)) state_d = TMR_COUNT;
            TMR_COUNT: if (load && (value == '0)) state_d = TMR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TMR_IDLE;
        else        state_q <= state_d;
    end

    // count and reload registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rld_q <= '0;
        end else if (load) begin
            cnt_q <= value;
            rld_q <= value;
        end else if ((state_q == TMR_COUNT) && tick) begin
            cnt_q <= (cnt_q == ONE) ? rld_q : cnt_q - ONE;
        end
    end

    // outputs
    always_comb begin
        zero_evt = 1'b0;
        unique case (state_q)
            TMR_IDLE:  zero_evt = 1'b0;
            TMR_COUNT: zero_evt = last_step;
        endcase
    end

endmodule

// File: rtl/vid_evt_regs.sv
module vid_evt_regs
    import vid_evt_irq_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] EN_ADDR = 8'hB4,
    parameter logic [ADDR_W-1:0] ST_ADDR = 8'hB5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [REG_W-1:0]  events,
    output logic [REG_W-1:0]  status_q,
    output logic [REG_W-1:0]  en_q,
    output logic              irq
);

    logic             hit_en;
    logic             hit_st;
    logic [REG_W-1:0] clr_mask;
    logic [REG_W-1:0] status_d;

    assign hit_en = (bus_addr == EN_ADDR);
    assign hit_st = (bus_addr == ST_ADDR);

    always_comb begin
        clr_mask = (bus_wr && hit_st) ? bus_wdata : '0;
        // an arriving event outranks a clear on the same bit
        status_d = ((status_q & ~clr_mask) | events) & LIVE_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            en_q     <= '0;
        end else begin
            status_q <= status_d;
            if (bus_wr && hit_en) en_q <= bus_wdata & LIVE_MASK;
        end
    end

    always_comb begin
        if (hit_en)      bus_rdata = en_q;
        else if (hit_st) bus_rdata = status_q;
        else             bus_rdata = '0;
    end

    assign irq = |(status_q & en_q);

endmodule

// File: rtl/vid_evt_irq.sv
module vid_evt_irq
    import vid_evt_irq_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                TMR_W   = 16,
    parameter logic [ADDR_W-1:0] EN_ADDR = 8'hB4,
    parameter logic [ADDR_W-1:0] ST_ADDR = 8'hB5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              disp_vsync,
    input  logic              cap_vsync,
    input  logic              hfreq_chg,
    input  logic              vfreq_chg,
    input  logic              tmr_tick,
    input  logic              tmr_load,
    input  logic [TMR_W-1:0]  tmr_value,
    output logic              irq
);

    logic [NUM_SYNC-1:0] sync_vec;
    logic [NUM_SYNC-1:0] lead_vec;
    logic [NUM_SYNC-1:0] trail_vec;
    logic                tmr_evt;
    logic [REG_W-1:0]    events;
    logic [REG_W-1:0]    status_q;
    logic [REG_W-1:0]    en_q;

    always_comb begin
        sync_vec            = '0;
        sync_vec[SYNC_DISP] = disp_vsync;
        sync_vec[SYNC_CAP]  = cap_vsync;
    end

    for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
        vid_sync_edge u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_in   (sync_vec[g]),
            .lead_evt  (lead_vec[g]),
            .trail_evt (trail_vec[g])
        );
    end

    vid_cdown_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .value    (tmr_value),
        .tick     (tmr_tick),
        .zero_evt (tmr_evt)
    );

    always_comb begin
        events                = '0;
        events[BIT_HFREQ]     = hfreq_chg;
        events[BIT_DISP_LEAD] = lead_vec[SYNC_DISP];
        events[BIT_DISP_TRL]  = trail_vec[SYNC_DISP];
        events[BIT_CAP_LEAD]  = lead_vec[SYNC_CAP];
        events[BIT_CAP_TRL]   = trail_vec[SYNC_CAP];
        events[BIT_VFREQ]     = vfreq_chg;
        events[BIT_TIMER]     = tmr_evt;
    end

    vid_evt_regs #(
        .ADDR_W  (ADDR_W),
        .EN_ADDR (EN_ADDR),
        .ST_ADDR (ST_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .events    (events),
        .status_q  (status_q),
        .en_q      (en_q),
        .irq       (irq)
    );

endmodule

// File: rtl/vid_evt_irq_chk.sv
module vid_evt_irq_chk #(
    parameter logic [7:0] ST_ADDR = 8'hB5
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       disp_vsync,
    input logic       cap_vsync,
    input logic       hfreq_chg,
    input logic       vfreq_chg,
    input logic       irq,
    input logic [7:0] status_q,
    input logic [7:0] en_q,
    input logic       tmr_evt
);

    p_bit0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !status_q[0] && !en_q[0]);

    p_disp_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_vsync) |=> status_q[6]);

    p_disp_trail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disp_vsync) |=> status_q[5]);

    p_cap_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_vsync) |=> status_q[4]);

    p_cap_trail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_vsync) |=> status_q[3]);

    p_freq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hfreq_chg || vfreq_chg) |=> (status_q[7] || status_q[2]));

    p_timer_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_evt |=> status_q[1]);

    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == 8'h00) |-> !irq);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ST_ADDR) && bus_wdata[7] && !hfreq_chg) |=> !status_q[7]);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ST_ADDR) && hfreq_chg) |=> status_q[7]);

endmodule

bind vid_evt_irq vid_evt_irq_chk #(.ST_ADDR(ST_ADDR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .disp_vsync (disp_vsync),
    .cap_vsync  (cap_vsync),
    .hfreq_chg  (hfreq_chg),
    .vfreq_chg  (vfreq_chg),
    .irq        (irq),
    .status_q   (status_q),
    .en_q       (en_q),
    .tmr_evt    (tmr_evt)
);

// File: tb/vid_evt_irq_bench.sv
module vid_evt_irq_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_EN = 8'hB4;
    localparam logic [7:0] A_ST = 8'hB5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        disp_vsync, cap_vsync, hfreq_chg, vfreq_chg;
    logic        tmr_tick, tmr_load;
    logic [15:0] tmr_value;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] q_rd[$];
    logic       q_irq[$];
    string      q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_evt_irq u_vid_evt_irq (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .disp_vsync(disp_vsync),
        .cap_vsync(cap_vsync), .hfreq_chg(hfreq_chg), .vfreq_chg(vfreq_chg),
        .tmr_tick(tmr_tick), .tmr_load(tmr_load), .tmr_value(tmr_value), .irq(irq)
    );

    // monitor: pops expected items and compares mid-cycle
    always @(negedge clk) begin
        if (q_rd.size() != 0) begin
            logic [7:0] e_rd;
            logic       e_irq;
            string      tag;
            e_rd  = q_rd.pop_front();
            e_irq = q_irq.pop_front();
            tag   = q_tag.pop_front();
            checks++;
            if (bus_rdata !== e_rd || irq !== e_irq) begin
                errors++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         tag, bus_rdata, irq, e_rd, e_irq);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // driver: present a read and push the expectation
    task automatic expect_rd(input logic [7:0] a, input logic [7:0] rd,
                             input logic ir, input string tag);
        bus_addr = a;
        q_rd.push_back(rd);
        q_irq.push_back(ir);
        q_tag.push_back(tag);
        step(1);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        step(1);
        sig = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = 8'h00; bus_wr = 1'b0; bus_wdata = 8'h00;
        disp_vsync = 1'b0; cap_vsync = 1'b0; hfreq_chg = 1'b0; vfreq_chg = 1'b0;
        tmr_tick = 1'b0; tmr_load = 1'b0; tmr_value = 16'd0;
        step(3);
        rst_n = 1'b1;

        expect_rd(A_ST, 8'h00, 1'b0, "R1 status");
        expect_rd(A_EN, 8'h00, 1'b0, "R1 enable");

        wr(A_EN, 8'hFF);
        expect_rd(A_EN, 8'hFE, 1'b0, "R2 enable readback");
        wr(A_EN, 8'h00);

        disp_vsync = 1'b1; step(1);
        expect_rd(A_ST, 8'h40, 1'b0, "R3 disp lead, R8 latch while disabled");
        disp_vsync = 1'b0; step(1);
        expect_rd(A_ST, 8'h60, 1'b0, "R3 disp trail");
        wr(A_ST, 8'hFF);
        expect_rd(A_ST, 8'h00, 1'b0, "R9 clear all");

        cap_vsync = 1'b1; step(1);
        cap_vsync = 1'b0; step(1);
        expect_rd(A_ST, 8'h18, 1'b0, "R4 capture lead and trail");
        wr(A_ST, 8'h08);
        expect_rd(A_ST, 8'h10, 1'b0, "R9 zero bits untouched");
        wr(A_ST, 8'hFF);

        pulse(hfreq_chg);
        pulse(vfreq_chg);
        expect_rd(A_ST, 8'h84, 1'b0, "R5 frequency pulses");
        wr(A_ST, 8'hFF);

        wr(A_EN, 8'h80);
        pulse(hfreq_chg);
        expect_rd(A_ST, 8'h80, 1'b1, "R8 enabled source raises irq");
        wr(A_ST, 8'h80);
        expect_rd(A_ST, 8'h00, 1'b0, "R8 irq drops after clear");
        pulse(vfreq_chg);
        expect_rd(A_ST, 8'h04, 1'b0, "R8 disabled source no irq");
        wr(A_ST, 8'hFF);

        // R10: clear and event on the same edge
        bus_addr = A_ST; bus_wdata = 8'h80; bus_wr = 1'b1; hfreq_chg = 1'b1;
        step(1);
        bus_wr = 1'b0; hfreq_chg = 1'b0;
        expect_rd(A_ST, 8'h80, 1'b1, "R10 set beats clear");
        wr(A_ST, 8'hFF);
        wr(A_EN, 8'h00);

        // R6 timer
        wr(A_EN, 8'h02);
        tmr_value = 16'd5; tmr_load = 1'b1; step(1); tmr_load = 1'b0;
        tmr_tick = 1'b1; step(4); tmr_tick = 1'b0;
        expect_rd(A_ST, 8'h00, 1'b0, "R6 no event after N-1 ticks");
        expect_rd(A_ST, 8'h00, 1'b0, "R6 count held without tick");
        tmr_tick = 1'b1; step(1); tmr_tick = 1'b0;
        expect_rd(A_ST, 8'h02, 1'b1, "R6 event at N-th tick");
        wr(A_ST, 8'hFF);
        tmr_tick = 1'b1; step(4); tmr_tick = 1'b0;
        expect_rd(A_ST, 8'h00, 1'b0, "R6 reload not early");
        tmr_tick = 1'b1; step(1); tmr_tick = 1'b0;
        expect_rd(A_ST, 8'h02, 1'b1, "R6 periodic reload");
        wr(A_ST, 8'hFF);

        // R7 stop with zero load
        tmr_value = 16'd0; tmr_load = 1'b1; step(1); tmr_load = 1'b0;
        tmr_tick = 1'b1; step(20); tmr_tick = 1'b0;
        expect_rd(A_ST, 8'h00, 1'b0, "R7 zero load stops timer");
        wr(A_EN, 8'h00);

        // R11 other index
        pulse(hfreq_chg);
        wr(8'hB6, 8'hFF);
        wr(8'h10, 8'hFF);
        expect_rd(A_ST, 8'h80, 1'b0, "R11 status untouched by other index");
        expect_rd(A_EN, 8'h00, 1'b0, "R11 enable untouched by other index");
        expect_rd(8'h10, 8'h00, 1'b0, "R11 other index reads zero");

        step(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule